// File: doc/BRIEF.md
# Banked Memory Map Decoder

This block turns a 16-bit processor address and a read/write direction into a physical destination for the access. The destination can be main RAM, auxiliary RAM, the I/O page, the expansion-ROM window, one of two upper-area RAM banks, a card that has taken over the upper area, or system ROM. A small set of mode switches steers the choice. Some switches move the stack and zero page. Some move general RAM, separately for reads and for writes. A display-store mode moves only the text and hi-res display windows, and it uses the display page flag to pick the side.

The switches are loaded through a narrow register-write port. The destination is computed combinationally from the address, the direction and the stored switches. A bank index goes with the destination: the auxiliary block, the upper-RAM block or the ROM page. Requested block and page numbers are brought into the implemented range when they are written. The storage arrays and the arbitration of expansion-ROM ownership are outside the block. It only reports that the expansion window was addressed.

Top module: `mem_route_top`

## Requirements
- R1: `tgt_code` encodes the destination as 0 main RAM, 1 auxiliary RAM, 2 I/O, 3 expansion window, 4 upper RAM, 5 upper alternate 4K bank, 6 inhibiting card, 7 system ROM. `tgt_aux` is high exactly when the storage lies in auxiliary memory (code 1, or code 4/5 while the alternate-zero-page switch is set). `tgt_bank` is 0 for codes 0, 2, 3 and 6.
- R2: A write takes effect at the rising clock edge while `cfg_we` is high. `cfg_addr` 0 loads the switches from `cfg_data`: bit0 alternate zero page, bit1 auxiliary read, bit2 auxiliary write, bit3 display store, bit4 second page, bit5 hi-res. `cfg_addr` 1 loads bit0 upper read enable, bit1 upper write enable and bit2 alternate 4K bank. `cfg_addr` 2 is the upper block request, 3 the auxiliary block request and 4 the ROM page request. Writes to `cfg_addr` 5 to 7 change nothing.
- R3: Addresses 0x0000-0x01FF select auxiliary RAM (bank = auxiliary block) when alternate zero page is set and main RAM otherwise. This holds for reads and for writes.
- R4: With display store set, 0x0400-0x07FF selects auxiliary RAM if second page is set and main RAM if not, in both directions.
- R5: With display store and hi-res both set, 0x2000-0x3FFF follows second page in the same way. With hi-res clear, this range uses the R6 rule.
- R6: The remaining addresses in 0x0200-0xBFFF select auxiliary RAM according to auxiliary read for reads and auxiliary write for writes.
- R7: 0xC000-0xC0FF always gives code 2, and 0xC100-0xCFFF always gives code 3.
- R8: In 0xD000-0xFFFF, a high `inhibit` gives code 6 regardless of every switch.
- R9: Without inhibit, 0xD000-0xFFFF gives upper RAM when the upper read enable (for reads) or write enable (for writes) is set. Otherwise it gives code 7 with the ROM page as bank.
- R10: Upper RAM in 0xD000-0xDFFF gives code 5 when alternate 4K bank is set, and code 4 otherwise. 0xE000-0xFFFF always gives code 4. The bank is the auxiliary block with `tgt_aux` high when alternate zero page is set, and the upper block otherwise.
- R11: The upper block request is stored modulo UP_BLOCKS. An auxiliary block request of EXT_BLOCKS or more is stored as 0. The ROM page request is stored modulo ROM_PAGES.
- R12: Reset clears every switch, both enables, the alternate-bank flag and all three indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the switch registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Switch register write strobe |
| cfg_addr | input | 3 | Switch register select |
| cfg_data | input | 8 | Switch register write data |
| cpu_addr | input | 16 | Processor address being decoded |
| cpu_wr | input | 1 | 1 for a write access, 0 for a read |
| inhibit | input | 1 | A card claims 0xD000-0xFFFF |
| tgt_code | output | 3 | Destination code |
| tgt_aux | output | 1 | Destination storage lies in auxiliary memory |
| tgt_bank | output | 8 | Bank, block or page index for the destination |

## Verification
Two overrides can claim the same address at once. In the low area, the display-store windows compete with the direction-split auxiliary read/write switches. In the upper area, inhibit competes with the upper-RAM enables and the alternate-bank flag. The bench sweeps every switch combination against both ends of every page in both directions, so every conflicting pair is set together. It judges each result against an independently written priority model. A separate sweep of every block request value checks the folding of out-of-range indices.

// File: rtl/mem_route_pkg.sv
package mem_route_pkg;

  typedef enum logic [2:0] {
    TGT_MAIN  = 3'd0,
    TGT_AUX   = 3'd1,
    TGT_IO    = 3'd2,
    TGT_EXP   = 3'd3,
    TGT_UPPER = 3'd4,
    TGT_UPALT = 3'd5,
    TGT_INH   = 3'd6,
    TGT_ROM   = 3'd7
  } tgt_e;

  // bit0 first: alt_zp, aux_rd, aux_wr, store, page2, hires
  typedef struct packed {
    logic hires;
    logic page2;
    logic store;
    logic aux_wr;
    logic aux_rd;
    logic alt_zp;
  } sw_flags_t;

  typedef struct packed {
    logic alt4k;
    logic up_wr;
    logic up_rd;
  } sw_upper_t;

  localparam logic [15:0] ZP_LAST    = 16'h01FF;
  localparam logic [15:0] TEXT_FIRST = 16'h0400;
  localparam logic [15:0] TEXT_LAST  = 16'h07FF;
  localparam logic [15:0] HGR_FIRST  = 16'h2000;
  localparam logic [15:0] HGR_LAST   = 16'h3FFF;
  localparam logic [15:0] RAM_LAST   = 16'hBFFF;
  localparam logic [15:0] IO_LAST    = 16'hC0FF;
  localparam logic [15:0] EXP_LAST   = 16'hCFFF;
  localparam logic [15:0] ALT4K_LAST = 16'hDFFF;

  // Wrap a requested index into the implemented count.
  function automatic logic [7:0] fold_index(input logic [7:0] req, input int unsigned count);
    int unsigned r;
    r = {24'd0, req} % count;
    return r[7:0];
  endfunction

  // Replace an index beyond the implemented count by zero.
  function automatic logic [7:0] guard_index(input logic [7:0] req, input int unsigned count);
    return ({24'd0, req} < count) ? req : 8'd0;
  endfunction

endpackage

// File: rtl/mem_route_regs.sv
module mem_route_regs
  import mem_route_pkg::*;
#(
  parameter int unsigned UP_BLOCKS  = 8,
  parameter int unsigned EXT_BLOCKS = 16,
  parameter int unsigned ROM_PAGES  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [2:0] sel,
  input  logic [7:0] wdata,
  output sw_flags_t  flags,
  output sw_upper_t  upper,
  output logic [7:0] up_blk,
  output logic [7:0] ext_blk,
  output logic [7:0] rom_pg
);

  localparam int unsigned FLAG_W  = $bits(sw_flags_t);
  localparam int unsigned UPPER_W = $bits(sw_upper_t);

  logic hit_flags, hit_upper, hit_up_blk, hit_ext_blk, hit_rom;

  assign hit_flags   = we && (sel == 3'd0);
  assign hit_upper   = we && (sel == 3'd1);
  assign hit_up_blk  = we && (sel == 3'd2);
  assign hit_ext_blk = we && (sel == 3'd3);
  assign hit_rom     = we && (sel == 3'd4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags   <= '0;
      upper   <= '0;
      up_blk  <= '0;
      ext_blk <= '0;
      rom_pg  <= '0;
    end else begin
      if (hit_flags)   flags   <= sw_flags_t'(wdata[FLAG_W-1:0]);
      if (hit_upper)   upper   <= sw_upper_t'(wdata[UPPER_W-1:0]);
      if (hit_up_blk)  up_blk  <= fold_index(wdata, UP_BLOCKS);
      if (hit_ext_blk) ext_blk <= guard_index(wdata, EXT_BLOCKS);
      if (hit_rom)     rom_pg  <= fold_index(wdata, ROM_PAGES);
    end
  end

endmodule

// File: rtl/mem_route_low.sv
module mem_route_low
  import mem_route_pkg::*;
(
  input  logic [15:0] addr,
  input  logic        wr,
  input  sw_flags_t   flags,
  input  logic [7:0]  ext_blk,
  output logic [2:0]  code,
  output logic        aux,
  output logic [7:0]  bank
);

  logic in_zp, in_text, in_hgr, text_win, hgr_win, pick_aux;

  assign in_zp    = (addr <= ZP_LAST);
  assign in_text  = (addr >= TEXT_FIRST) && (addr <= TEXT_LAST);
  assign in_hgr   = (addr >= HGR_FIRST) && (addr <= HGR_LAST);
  assign text_win = flags.store && in_text;
  assign hgr_win  = flags.store && flags.hires && in_hgr;

  always_comb begin
    if (in_zp)                    pick_aux = flags.alt_zp;
    else if (text_win || hgr_win) pick_aux = flags.page2;
    else if (wr)                  pick_aux = flags.aux_wr;
    else                          pick_aux = flags.aux_rd;
  end

  assign code = pick_aux ? TGT_AUX : TGT_MAIN;
  assign aux  = pick_aux;
  assign bank = pick_aux ? ext_blk : 8'd0;

endmodule

// File: rtl/mem_route_high.sv
module mem_route_high
  import mem_route_pkg::*;
(
  input  logic [15:0] addr,
  input  logic        wr,
  input  logic        inhibit,
  input  logic        alt_zp,
  input  sw_upper_t   upper,
  input  logic [7:0]  up_blk,
  input  logic [7:0]  ext_blk,
  input  logic [7:0]  rom_pg,
  output logic [2:0]  code,
  output logic        aux,
  output logic [7:0]  bank
);

  logic in_io, in_exp, in_4k, up_on;

  assign in_io  = (addr <= IO_LAST);
  assign in_exp = (addr <= EXP_LAST);
  assign in_4k  = (addr <= ALT4K_LAST);
  assign up_on  = wr ? upper.up_wr : upper.up_rd;

  always_comb begin
    code = TGT_ROM;
    aux  = 1'b0;
    bank = 8'd0;
    if (in_io) begin
      code = TGT_IO;
    end else if (in_exp) begin
      code = TGT_EXP;
    end else if (inhibit) begin
      code = TGT_INH;
    end else if (up_on) begin
      code = (upper.alt4k && in_4k) ? TGT_UPALT : TGT_UPPER;
      aux  = alt_zp;
      bank = alt_zp ? ext_blk : up_blk;
    end else begin
      code = TGT_ROM;
      bank = rom_pg;
    end
  end

endmodule

// File: rtl/mem_route_top.sv
module mem_route_top
  import mem_route_pkg::*;
#(
  parameter int unsigned UP_BLOCKS  = 8,
  parameter int unsigned EXT_BLOCKS = 16,
  parameter int unsigned ROM_PAGES  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_addr,
  input  logic [7:0]  cfg_data,
  input  logic [15:0] cpu_addr,
  input  logic        cpu_wr,
  input  logic        inhibit,
  output logic [2:0]  tgt_code,
  output logic        tgt_aux,
  output logic [7:0]  tgt_bank
);

  sw_flags_t  sw_flags;
  sw_upper_t  sw_upper;
  logic [7:0] up_blk, ext_blk, rom_pg;
  logic [2:0] lo_code, hi_code;
  logic       lo_aux, hi_aux, low_half;
  logic [7:0] lo_bank, hi_bank;

  mem_route_regs #(
    .UP_BLOCKS(UP_BLOCKS), .EXT_BLOCKS(EXT_BLOCKS), .ROM_PAGES(ROM_PAGES)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_addr), .wdata(cfg_data),
    .flags(sw_flags), .upper(sw_upper), .up_blk(up_blk), .ext_blk(ext_blk), .rom_pg(rom_pg)
  );

  mem_route_low u_low (
    .addr(cpu_addr), .wr(cpu_wr), .flags(sw_flags), .ext_blk(ext_blk),
    .code(lo_code), .aux(lo_aux), .bank(lo_bank)
  );

  mem_route_high u_high (
    .addr(cpu_addr), .wr(cpu_wr), .inhibit(inhibit), .alt_zp(sw_flags.alt_zp),
    .upper(sw_upper), .up_blk(up_blk), .ext_blk(ext_blk), .rom_pg(rom_pg),
    .code(hi_code), .aux(hi_aux), .bank(hi_bank)
  );

  assign low_half = (cpu_addr <= RAM_LAST);
  assign tgt_code = low_half ? lo_code : hi_code;
  assign tgt_aux  = low_half ? lo_aux  : hi_aux;
  assign tgt_bank = low_half ? lo_bank : hi_bank;

endmodule

// File: rtl/mem_route_chk.sv
module mem_route_chk #(
  parameter int unsigned UP_BLOCKS  = 8,
  parameter int unsigned EXT_BLOCKS = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [2:0]  cfg_addr,
  input logic [7:0]  cfg_data,
  input logic [15:0] cpu_addr,
  input logic        inhibit,
  input logic [2:0]  tgt_code,
  input logic        tgt_aux,
  input logic [7:0]  tgt_bank,
  input logic [5:0]  sw_bits
);

  assert_flag_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 3'd0) |=> (sw_bits == $past(cfg_data[5:0])));

  assert_stack_side_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr < 16'h0200) |-> (tgt_code == (sw_bits[0] ? 3'd1 : 3'd0)));

  assert_io_page_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:8] == 8'hC0) |-> (tgt_code == 3'd2 && tgt_bank == 8'd0 && !tgt_aux));

  assert_inhibit_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit && cpu_addr >= 16'hD000) |-> (tgt_code == 3'd6));

  assert_aux_bank_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_aux |-> (tgt_bank < EXT_BLOCKS));

  assert_upper_bank_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((tgt_code == 3'd4 || tgt_code == 3'd5) && !tgt_aux) |-> (tgt_bank < UP_BLOCKS));

  assert_reset_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (sw_bits == 6'd0));

endmodule

bind mem_route_top mem_route_chk #(.UP_BLOCKS(UP_BLOCKS), .EXT_BLOCKS(EXT_BLOCKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
  .cpu_addr(cpu_addr), .inhibit(inhibit), .tgt_code(tgt_code), .tgt_aux(tgt_aux),
  .tgt_bank(tgt_bank), .sw_bits(sw_flags)
);

// File: tb/mem_route_top_test.sv
module mem_route_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int UPB = 6;
  localparam int EXB = 12;
  localparam int ROMP = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [7:0]  cfg_data = '0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_wr = 1'b0;
  logic        inhibit = 1'b0;
  logic [2:0]  tgt_code;
  logic        tgt_aux;
  logic [7:0]  tgt_bank;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic done = 1'b0;

  // bench shadows of what was written
  logic [5:0] sh_flags = '0;
  logic [2:0] sh_upper = '0;
  logic [7:0] sh_up = '0, sh_ext = '0, sh_rom = '0;

  mem_route_top #(.UP_BLOCKS(UPB), .EXT_BLOCKS(EXB), .ROM_PAGES(ROMP)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .inhibit(inhibit),
    .tgt_code(tgt_code), .tgt_aux(tgt_aux), .tgt_bank(tgt_bank)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run did not complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp, input logic [15:0] a);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s addr=%h actual code/aux/bank=%0d/%0d/%0d expected %0d/%0d/%0d",
               tag, a, act[11:9], act[8], act[7:0], exp[11:9], exp[8], exp[7:0]);
    end
  endtask

  task automatic wr_cfg(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = sel; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Priority model written from the requirement list, page by page.
  function automatic logic [11:0] model(input logic [15:0] a, input logic w, input logic [5:0] f,
                                        input logic [2:0] u, input logic inh,
                                        input logic [7:0] bu, input logic [7:0] be, input logic [7:0] br);
    logic [2:0] c;
    logic x;
    logic [7:0] b;
    logic s;
    logic en;
    int pg;
    pg = int'(a[15:8]);
    c = 3'd0; x = 1'b0; b = 8'd0; s = 1'b0;
    if (pg < 8'hC0) begin
      if (pg < 2) s = f[0];
      else if (f[3] && pg >= 4 && pg <= 7) s = f[4];
      else if (f[3] && f[5] && pg >= 8'h20 && pg <= 8'h3F) s = f[4];
      else s = w ? f[2] : f[1];
      c = s ? 3'd1 : 3'd0;
      x = s;
      b = s ? be : 8'd0;
    end else if (pg == 8'hC0) c = 3'd2;
    else if (pg < 8'hD0) c = 3'd3;
    else if (inh) c = 3'd6;
    else begin
      en = w ? u[1] : u[0];
      if (!en) begin c = 3'd7; b = br; end
      else begin
        c = (u[2] && pg < 8'hE0) ? 3'd5 : 3'd4;
        x = f[0];
        b = f[0] ? be : bu;
      end
    end
    return {c, x, b};
  endfunction

  function automatic string low_tag(input int pg, input logic [5:0] f);
    if (pg < 2) return "R3";
    if (f[3] && pg >= 4 && pg <= 7) return "R4";
    if (f[3] && pg >= 8'h20 && pg <= 8'h3F) return "R5";
    return "R6";
  endfunction

  function automatic string high_tag(input int pg, input logic inh, input logic [2:0] u);
    if (pg < 8'hD0) return "R7";
    if (inh) return "R8";
    if (u[2] && (u[0] || u[1])) return "R10";
    return "R9";
  endfunction

  task automatic probe(input string tag, input logic [15:0] a, input logic w, input logic inh);
    cpu_addr = a; cpu_wr = w; inhibit = inh;
    #1;
    chk(tag, {tgt_code, tgt_aux, tgt_bank},
        model(a, w, sh_flags, sh_upper, inh, sh_up, sh_ext, sh_rom), a);
  endtask

  task automatic reset_checks(input string tag);
    // all switches clear: low area main, upper disabled -> ROM page 0
    cpu_addr = 16'h0000; cpu_wr = 1'b0; inhibit = 1'b0; #1;
    chk(tag, {tgt_code, tgt_aux, tgt_bank}, {3'd0, 1'b0, 8'd0}, cpu_addr);
    cpu_addr = 16'h0300; cpu_wr = 1'b1; #1;
    chk(tag, {tgt_code, tgt_aux, tgt_bank}, {3'd0, 1'b0, 8'd0}, cpu_addr);
    cpu_addr = 16'h0400; cpu_wr = 1'b0; #1;
    chk(tag, {tgt_code, tgt_aux, tgt_bank}, {3'd0, 1'b0, 8'd0}, cpu_addr);
    cpu_addr = 16'hE000; #1;
    chk(tag, {tgt_code, tgt_aux, tgt_bank}, {3'd7, 1'b0, 8'd0}, cpu_addr);
    cpu_addr = 16'hD000; cpu_wr = 1'b1; #1;
    chk(tag, {tgt_code, tgt_aux, tgt_bank}, {3'd7, 1'b0, 8'd0}, cpu_addr);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    reset_checks("R12");

    // R1: codes for each region with plain settings
    cpu_addr = 16'hC000; cpu_wr = 1'b0; #1;
    chk("R1", {tgt_code, tgt_aux, tgt_bank}, {3'd2, 1'b0, 8'd0}, cpu_addr);
    cpu_addr = 16'hC800; #1;
    chk("R1", {tgt_code, tgt_aux, tgt_bank}, {3'd3, 1'b0, 8'd0}, cpu_addr);

    // R11 and R2 for index registers
    wr_cfg(3'd2, 8'd9); sh_up = 8'd3;
    wr_cfg(3'd3, 8'd5); sh_ext = 8'd5;
    wr_cfg(3'd4, 8'd6); sh_rom = 8'd2;

    // low area sweep: R3-R6
    for (int f = 0; f < 64; f++) begin
      wr_cfg(3'd0, 8'(f)); sh_flags = 6'(f);
      for (int pg = 0; pg < 8'hC0; pg++)
        for (int w = 0; w < 2; w++) begin
          probe(low_tag(pg, sh_flags), {8'(pg), 8'h00}, w[0], 1'b0);
          probe(low_tag(pg, sh_flags), {8'(pg), 8'hFF}, w[0], 1'b0);
        end
    end

    // R2: writes to unused selects leave flags alone
    wr_cfg(3'd0, 8'h01); sh_flags = 6'h01;
    wr_cfg(3'd5, 8'hFE);
    wr_cfg(3'd6, 8'h00);
    wr_cfg(3'd7, 8'h00);
    probe("R2", 16'h0100, 1'b0, 1'b0);
    probe("R2", 16'h0800, 1'b1, 1'b0);
    probe("R2", 16'hE000, 1'b0, 1'b0);

    // high area sweep: R7-R10
    for (int z = 0; z < 2; z++) begin
      wr_cfg(3'd0, 8'(z)); sh_flags = 6'(z);
      for (int u = 0; u < 8; u++) begin
        wr_cfg(3'd1, 8'(u)); sh_upper = 3'(u);
        for (int pg = 8'hC0; pg < 256; pg++)
          for (int w = 0; w < 2; w++)
            for (int h = 0; h < 2; h++) begin
              probe(high_tag(pg, h[0], sh_upper), {8'(pg), 8'h00}, w[0], h[0]);
              probe(high_tag(pg, h[0], sh_upper), {8'(pg), 8'hFF}, w[0], h[0]);
            end
      end
    end

    // R11: every upper block request folds modulo UPB
    wr_cfg(3'd0, 8'h00); sh_flags = '0;
    wr_cfg(3'd1, 8'h01); sh_upper = 3'd1;
    for (int r = 0; r < 256; r++) begin
      wr_cfg(3'd2, 8'(r));
      cpu_addr = 16'hE123; cpu_wr = 1'b0; inhibit = 1'b0; #1;
      chk("R11", {tgt_code, tgt_aux, tgt_bank}, {3'd4, 1'b0, 8'(r % UPB)}, cpu_addr);
    end
    // R11: auxiliary block request beyond EXB becomes 0
    wr_cfg(3'd0, 8'h01); sh_flags = 6'h01;
    for (int r = 0; r < 256; r++) begin
      wr_cfg(3'd3, 8'(r));
      cpu_addr = 16'h0042; cpu_wr = 1'b1; #1;
      chk("R11", {tgt_code, tgt_aux, tgt_bank}, {3'd1, 1'b1, (r < EXB) ? 8'(r) : 8'd0}, cpu_addr);
    end
    // R11: ROM page folds modulo ROMP
    wr_cfg(3'd1, 8'h00); sh_upper = 3'd0;
    for (int r = 0; r < 16; r++) begin
      wr_cfg(3'd4, 8'(r));
      cpu_addr = 16'hF800; cpu_wr = 1'b0; #1;
      chk("R11", {tgt_code, tgt_aux, tgt_bank}, {3'd7, 1'b0, 8'(r % ROMP)}, cpu_addr);
    end

    // R12: load everything, then reset mid-run
    wr_cfg(3'd0, 8'h3F);
    wr_cfg(3'd1, 8'h07);
    wr_cfg(3'd2, 8'd4);
    wr_cfg(3'd3, 8'd7);
    wr_cfg(3'd4, 8'd3);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    reset_checks("R12");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule